// File: doc/BRIEF.md
# Ring Node Transmit Insertion Arbiter

This block sits at the output of one node on a unidirectional ring. Traffic that arrives from the upstream neighbour is queued in a pass-through FIFO and forwarded. Words that the local host wants to send wait in a local transmit FIFO. Each cycle the block decides which source, if either, drives the single ring output. Every word carries the identifier of the node that created it. When a word comes back around the ring carrying this node's identifier, the block removes it instead of forwarding it. That removal clears the node's outstanding-message flag and opens a guaranteed slot for the next local word.

Forwarded traffic normally comes before local traffic. A local word is sent on its own only into a gap: the pass-through FIFO is empty and no message of this node is still travelling. A node whose ring stays busy still makes progress in two ways. The return of its own message grants an insertion slot, and so does the expiry of a programmable 16-bit time-out that starts each time a local word leaves. The block runs in burst fashion: a local word is sent exactly once and is never queued again, whether it returns or times out. When several nodes burst at once, each gets roughly an equal share of the link.

Top module: `ring_insert_arb`

## Requirements
- R1: After reset `out_valid` and `own_pending` are 0, and `up_ready` is 1.
- R2: A word offered upstream whose `up_src` differs from `node_id` is forwarded unchanged (same source and data), in arrival order with other forwarded words.
- R3: A word offered upstream whose `up_src` equals `node_id` is always accepted (`up_ready` = 1) and never appears at the output. Each local word leaves exactly once, with `out_src` equal to `node_id`.
- R4: When the pass-through FIFO is empty and `own_pending` is 0, the head of the local FIFO is sent. The cycle after it is loaded into the output, `own_pending` is 1.
- R5: While `own_pending` is 1 and no insertion slot is held, no local word is sent, even if the pass-through FIFO is empty. Queued forwarded words go out ahead of queued local words.
- R6: Removing a returning own word clears `own_pending` and grants an insertion slot. The next local word then goes out ahead of any forwarded word still queued.
- R7: A local send loads the time-out counter with the reload value L. `own_pending` stays 1 for exactly L cycles, then clears and grants an insertion slot. The slot is held until a local word uses it.
- R8: The reload value resets to `TMO_INIT`. A `tmo_wr_en` pulse with a non-zero `tmo_wr_data` replaces it. A write of zero is ignored and the previous value stays in use.
- R9: The output follows a valid/ready handshake and transfers at most one word per cycle. While `out_valid` is 1 and `out_ready` is 0, `out_src` and `out_data` hold steady.
- R10: Once the output stage and all `PT_DEPTH` pass-through entries hold words, `up_ready` is 0 for a foreign word but stays 1 for an own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ID_W | Identifier of this node |
| tmo_wr_en | input | 1 | Write strobe for the time-out reload value |
| tmo_wr_data | input | TMO_W | New reload value; zero is ignored |
| up_valid | input | 1 | Upstream word present |
| up_src | input | ID_W | Source identifier of the upstream word |
| up_data | input | DATA_W | Payload of the upstream word |
| up_ready | output | 1 | Upstream word accepted this cycle |
| tx_valid | input | 1 | Local word offered to the transmit FIFO |
| tx_data | input | DATA_W | Payload of the local word |
| tx_ready | output | 1 | Transmit FIFO has room |
| out_valid | output | 1 | Ring output holds a word |
| out_src | output | ID_W | Source identifier of the output word |
| out_data | output | DATA_W | Payload of the output word |
| out_ready | input | 1 | Downstream takes the output word |
| own_pending | output | 1 | A local word is outstanding on the ring |

## Verification
The bench parks forwarded words behind a stalled output while a local word waits. It then opens the slot by a returning own word in one case and by time-out expiry in the other. A design that does not grant the slot lets the local word slip behind the queued forwarded word, and the order at the output shows it. It measures the outstanding window after the default reload, after a non-zero write and after a zero write. An off-by-one counter, or a zero write that is taken, changes the measured length. It also fills the pass-through path to the brim and offers both a foreign and an own word. A design that blocks its own returning word, or that forwards it or sends a local word twice, shows up as a refused handshake or as an unexpected word in the scoreboard.

// File: rtl/rim_pkg.sv
`timescale 1ns/1ps
package rim_pkg;
   // which source feeds the output stage this cycle
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_FWD   = 2'd1,
      SEL_LOCAL = 2'd2
   } rim_sel_e;
endpackage

// File: rtl/rim_fifo.sv
`timescale 1ns/1ps
module rim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin : prm_chk
      assert (DEPTH >= 1 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rim_fifo: DEPTH must be a power of two");
      assert (W >= 1) else $error("rim_fifo: W must be positive");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         logic         full_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    full_q <= 1'b0;
            else if (push) full_q <= 1'b1;
            else if (pop)  full_q <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) hold_q <= wdata;
         end
         assign rdata = hold_q;
         assign empty = !full_q;
         assign full  = full_q;
      end else begin : g_ring
         localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wp_q, rp_q;
         logic [AW:0]   cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wp_q <= wp_q + 1'b1;
               if (pop)  rp_q <= rp_q + 1'b1;
               unique case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp_q] <= wdata;
         end
         assign rdata = mem[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == FULL_CNT);
      end
   endgenerate

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/rim_timer.sv
`timescale 1ns/1ps
module rim_timer #(
   parameter int          TW       = 16,
   parameter int unsigned TMO_INIT = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   input  logic          start,   // local word sent this cycle
   input  logic          hit,     // own word stripped this cycle
   output logic          pending,
   output logic          slot
);
   localparam logic [TW-1:0] INIT_V = TW'(TMO_INIT);

   initial begin : prm_chk
      assert (TW >= 2 && TW <= 31) else $error("rim_timer: TW out of range");
      assert (TMO_INIT != 0 && TMO_INIT < (32'd1 << TW))
         else $error("rim_timer: TMO_INIT must be non-zero and fit TW bits");
   end

   logic [TW-1:0] reload_q, cnt_q;
   logic          pend_q, slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          reload_q <= INIT_V;
      else if (wr_en && wr_data != '0)     reload_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         slot_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= reload_q;
         pend_q <= 1'b1;
         slot_q <= 1'b0;
      end else if (hit) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         slot_q <= 1'b1;
      end else if (pend_q) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == TW'(1)) begin
            pend_q <= 1'b0;
            slot_q <= 1'b1;
         end
      end
   end

   assign pending = pend_q;
   assign slot    = slot_q;

   // R8
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == '0) |=> $stable(reload_q));
   // R7
   expiry_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q == TW'(1) && !start && !hit) |=> (!pend_q && slot_q));
   // R7
   live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q != '0));
endmodule

// File: rtl/rim_sel.sv
`timescale 1ns/1ps
module rim_sel
   import rim_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_ok,
   input  logic     pt_empty,
   input  logic     tx_empty,
   input  logic     pending,
   input  logic     slot,
   input  logic     hit,
   output rim_sel_e sel
);
   logic local_ok;

   // a held slot or a strip this cycle lets a local word cut in
   assign local_ok = !tx_empty && (slot || hit || (pt_empty && !pending));

   always_comb begin
      if (!load_ok)      sel = SEL_NONE;
      else if (local_ok) sel = SEL_LOCAL;
      else if (!pt_empty) sel = SEL_FWD;
      else               sel = SEL_NONE;
   end

   // R5
   fwd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !slot && !hit) |-> (sel != SEL_LOCAL));
endmodule

// File: rtl/ring_insert_arb.sv
`timescale 1ns/1ps
module ring_insert_arb #(
   parameter int          ID_W     = 4,
   parameter int          DATA_W   = 16,
   parameter int          PT_DEPTH = 4,
   parameter int          TX_DEPTH = 4,
   parameter int          TMO_W    = 16,
   parameter int unsigned TMO_INIT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   node_id,
   input  logic              tmo_wr_en,
   input  logic [TMO_W-1:0]  tmo_wr_data,
   input  logic              up_valid,
   input  logic [ID_W-1:0]   up_src,
   input  logic [DATA_W-1:0] up_data,
   output logic              up_ready,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              out_valid,
   output logic [ID_W-1:0]   out_src,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   output logic              own_pending
);
   import rim_pkg::*;

   localparam int PT_W = ID_W + DATA_W;

   initial begin : prm_chk
      assert (ID_W >= 1 && DATA_W >= 1) else $error("ring_insert_arb: bad widths");
   end

   logic              hit, pt_push, pt_empty, pt_full, tx_push, tx_empty, tx_full;
   logic              load_ok, slot;
   logic [PT_W-1:0]   pt_head;
   logic [DATA_W-1:0] tx_head;
   logic              ov_q;
   logic [ID_W-1:0]   os_q;
   logic [DATA_W-1:0] od_q;
   rim_sel_e          sel;

   assign hit      = up_valid && (up_src == node_id);
   assign up_ready = hit || !pt_full;
   assign pt_push  = up_valid && !hit && !pt_full;
   assign tx_ready = !tx_full;
   assign tx_push  = tx_valid && !tx_full;
   assign load_ok  = !ov_q || out_ready;

   rim_fifo #(.W(PT_W), .DEPTH(PT_DEPTH)) pt_fifo_i (
      .clk(clk), .rst_n(rst_n), .push(pt_push), .wdata({up_src, up_data}),
      .pop(sel == SEL_FWD), .rdata(pt_head), .empty(pt_empty), .full(pt_full));

   rim_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
      .pop(sel == SEL_LOCAL), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

   rim_timer #(.TW(TMO_W), .TMO_INIT(TMO_INIT)) timer_i (
      .clk(clk), .rst_n(rst_n), .wr_en(tmo_wr_en), .wr_data(tmo_wr_data),
      .start(sel == SEL_LOCAL), .hit(hit), .pending(own_pending), .slot(slot));

   rim_sel sel_i (
      .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .pt_empty(pt_empty),
      .tx_empty(tx_empty), .pending(own_pending), .slot(slot), .hit(hit),
      .sel(sel));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q <= 1'b0;
         os_q <= '0;
         od_q <= '0;
      end else if (load_ok) begin
         ov_q <= (sel != SEL_NONE);
         if (sel == SEL_FWD) begin
            os_q <= pt_head[PT_W-1:DATA_W];
            od_q <= pt_head[DATA_W-1:0];
         end else if (sel == SEL_LOCAL) begin
            os_q <= node_id;
            od_q <= tx_head;
         end
      end
   end

   assign out_valid = ov_q;
   assign out_src   = os_q;
   assign out_data  = od_q;

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_src) && $stable(out_data)));
   // R4
   send_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_LOCAL) |=> (own_pending && out_valid && out_src == $past(node_id)));
   // R6
   strip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel != SEL_LOCAL) |=> !own_pending);
   // R3
   own_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> up_ready);
endmodule

// File: tb/ring_insert_arb_tb_top.sv
`timescale 1ns/1ps
module ring_insert_arb_tb_top;
   localparam int          ID_W = 4;
   localparam int          DW   = 16;
   localparam int unsigned TINI = 30;
   localparam logic [3:0]  ME   = 4'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmo_wr_en = 1'b0;
   logic [15:0]   tmo_wr_data = '0;
   logic          up_valid = 1'b0;
   logic [3:0]    up_src = '0;
   logic [15:0]   up_data = '0;
   logic          up_ready;
   logic          tx_valid = 1'b0;
   logic [15:0]   tx_data = '0;
   logic          tx_ready;
   logic          out_valid;
   logic [3:0]    out_src;
   logic [15:0]   out_data;
   logic          out_ready = 1'b1;
   logic          own_pending;

   always #10 clk = ~clk;   // 50 MHz

   ring_insert_arb #(.ID_W(ID_W), .DATA_W(DW), .PT_DEPTH(4), .TX_DEPTH(4),
                     .TMO_W(16), .TMO_INIT(TINI)) dut_i (
      .clk(clk), .rst_n(rst_n), .node_id(ME),
      .tmo_wr_en(tmo_wr_en), .tmo_wr_data(tmo_wr_data),
      .up_valid(up_valid), .up_src(up_src), .up_data(up_data), .up_ready(up_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
      .out_ready(out_ready), .own_pending(own_pending));

   typedef struct {
      logic [3:0]  src;
      logic [15:0] data;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   exp_t        e;
   int          n_chk = 0;
   int          n_bad = 0;
   logic        stall_p = 1'b0;
   logic [3:0]  p_src;
   logic [15:0] p_data;

   task automatic expect_word(input logic [3:0] s, input logic [15:0] d, input string t);
      exp_t x;
      x.src = s; x.data = d; x.tag = t;
      sb_q.push_back(x);
   endtask

   task automatic peek();
      @(negedge clk); #5;
   endtask

   task automatic check(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic send_up(input logic [3:0] s, input logic [15:0] d);
      @(negedge clk);
      up_valid = 1'b1; up_src = s; up_data = d;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic send_tx(input logic [15:0] d);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = d;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic write_tmo(input logic [15:0] v);
      @(negedge clk);
      tmo_wr_en = 1'b1; tmo_wr_data = v;
      @(negedge clk);
      tmo_wr_en = 1'b0;
   endtask

   task automatic measure_pending(input int exp_len, input string t);
      int n = 0;
      int g = 0;
      peek();
      while (!own_pending && g < 20) begin peek(); g++; end
      while (own_pending && n < 70000) begin n++; peek(); end
      check(n == exp_len, t, n, exp_len);
   endtask

   task automatic wait_idle(input string t);
      int g = 0;
      peek();
      while ((sb_q.size() != 0 || out_valid || own_pending) && g < 500) begin
         peek(); g++;
      end
      check(g < 500, t, sb_q.size(), 0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (stall_p) begin
            n_chk++;
            if (!(out_valid && out_src == p_src && out_data == p_data)) begin
               n_bad++;
               $display("FAIL R9 hold: actual %0d/%h expected %0d/%h",
                        out_src, out_data, p_src, p_data);
            end
         end
         if (out_valid && out_ready) begin
            n_chk++;
            if (sb_q.size() == 0) begin
               n_bad++;
               $display("FAIL R3 unexpected word: actual %0d/%h expected none",
                        out_src, out_data);
            end else begin
               e = sb_q.pop_front();
               if (out_src != e.src || out_data != e.data) begin
                  n_bad++;
                  $display("FAIL %s order: actual %0d/%h expected %0d/%h",
                           e.tag, out_src, out_data, e.src, e.data);
               end
            end
         end
         stall_p = out_valid && !out_ready;
         p_src   = out_src;
         p_data  = out_data;
      end
   end

   // watchdog
   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit quiet;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      peek();
      // R1 reset state
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(own_pending == 1'b0, "R1 own_pending", own_pending, 0);
      check(up_ready == 1'b1, "R1 up_ready", up_ready, 1);

      // R4 immediate send, R7/R8 default reload length
      expect_word(ME, 16'h00A1, "R4");
      send_tx(16'h00A1);
      measure_pending(TINI, "R8 reset reload / R7 window");

      // R8 non-zero write takes effect
      write_tmo(16'd40);
      expect_word(ME, 16'h00A2, "R4");
      send_tx(16'h00A2);
      measure_pending(40, "R8 written reload");

      // R8 zero write ignored
      write_tmo(16'd0);
      expect_word(ME, 16'h00A3, "R4");
      send_tx(16'h00A3);
      measure_pending(40, "R8 zero write ignored");

      // R5 local word held while pending, even with empty forward path
      expect_word(ME, 16'h00A4, "R4");
      send_tx(16'h00A4);
      repeat (3) peek();
      expect_word(ME, 16'h00A5, "R5");
      send_tx(16'h00A5);
      quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
         peek();
         if (out_valid) quiet = 1'b0;
      end
      check(quiet, "R5 no send while pending", !quiet, 0);
      wait_idle("R5 drain");

      // R2 forwarding order
      expect_word(4'd1, 16'h0100, "R2");
      expect_word(4'd2, 16'h0101, "R2");
      expect_word(4'd5, 16'h0102, "R2");
      expect_word(4'd1, 16'h0103, "R2");
      send_up(4'd1, 16'h0100);
      send_up(4'd2, 16'h0101);
      send_up(4'd5, 16'h0102);
      send_up(4'd1, 16'h0103);
      wait_idle("R2 drain");

      // R6 strip grants slot: local word jumps queued forward word
      expect_word(ME, 16'h00B0, "R4");
      send_tx(16'h00B0);
      repeat (2) @(negedge clk);
      out_ready = 1'b0;
      send_up(4'd1, 16'h0F01);
      send_up(4'd2, 16'h0F02);
      send_tx(16'h00B1);
      peek();
      check(out_valid && out_data == 16'h0F01, "R9 stalled head", out_data, 16'h0F01);
      check(own_pending == 1'b1, "R5 still pending", own_pending, 1);
      @(negedge clk);
      up_valid = 1'b1; up_src = ME; up_data = 16'h00EE;
      #5;
      check(up_ready == 1'b1, "R3 own word accepted", up_ready, 1);
      @(negedge clk);
      up_valid = 1'b0;
      #5;
      check(own_pending == 1'b0, "R6 strip clears pending", own_pending, 0);
      expect_word(4'd1, 16'h0F01, "R6");
      expect_word(ME,   16'h00B1, "R6");
      expect_word(4'd2, 16'h0F02, "R6");
      @(negedge clk);
      out_ready = 1'b1;
      wait_idle("R6 drain");

      // R7 time-out grants slot
      expect_word(ME, 16'h00C0, "R4");
      send_tx(16'h00C0);
      repeat (2) @(negedge clk);
      out_ready = 1'b0;
      send_up(4'd1, 16'h0F03);
      send_up(4'd2, 16'h0F04);
      send_tx(16'h00C1);
      repeat (45) peek();
      check(own_pending == 1'b0, "R7 time-out cleared pending", own_pending, 0);
      expect_word(4'd1, 16'h0F03, "R7");
      expect_word(ME,   16'h00C1, "R7");
      expect_word(4'd2, 16'h0F04, "R7");
      @(negedge clk);
      out_ready = 1'b1;
      wait_idle("R7 drain");

      // R9 toggling ready while forwarding
      for (int i = 0; i < 4; i++) expect_word(4'd6, 16'h0200 + 16'(i), "R9");
      fork
         begin
            for (int i = 0; i < 4; i++) send_up(4'd6, 16'h0200 + 16'(i));
         end
         begin
            for (int i = 0; i < 24; i++) begin
               @(negedge clk);
               out_ready = (i % 3) != 0;
            end
            out_ready = 1'b1;
         end
      join
      wait_idle("R9 drain");

      // R10 back-pressure on foreign words only
      out_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin
         expect_word(4'd7, 16'h0300 + 16'(i), "R10");
         send_up(4'd7, 16'h0300 + 16'(i));
      end
      @(negedge clk);
      up_valid = 1'b1; up_src = 4'd7; up_data = 16'h03FF;
      #5;
      check(up_ready == 1'b0, "R10 full refuses foreign", up_ready, 0);
      @(negedge clk);
      up_src = ME; up_data = 16'h00EF;
      #5;
      check(up_ready == 1'b1, "R10 full still takes own", up_ready, 1);
      @(negedge clk);
      up_valid = 1'b0;
      out_ready = 1'b1;
      wait_idle("R10 drain");

      check(sb_q.size() == 0, "R3 scoreboard empty", sb_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule